// File: doc/BRIEF.md
# Hardware Spinlock Bank

A bank of hardware mutex locks that software on one or more bus masters uses to guard shared resources. Each lock occupies its own word address. Reading a lock's address is an atomic test-and-set: if the lock was free, it becomes held and the read returns a word with only that lock's bit set. If it was already held, the read returns zero and nothing changes. Writing any value to a lock's address frees it. A separate status word shows every lock's state at once and can be read without side effects.

The bus is a plain synchronous register port with a read strobe, a write strobe, a byte address and write data. Read data is registered and appears one cycle after the strobe, together with a one-cycle `rsp_valid` pulse. There is no back-pressure: the block accepts every access in the cycle it is presented. At most one access is presented per cycle. Arbitrating between masters is the job of the interconnect in front of the bank.

Top module: `hw_lock_bank`

## Requirements
- R1: After reset all locks are free, `rsp_valid` is 0 and `rsp_rdata` is 0.
- R2: A read of the address of a free lock n sets lock n held and returns a word with only bit n set.
- R3: A read of the address of a held lock n returns 0 and leaves the state of every lock unchanged.
- R4: A write of any data value to the address of lock n frees lock n and leaves every other lock unchanged. Writing to an already free lock keeps it free.
- R5: A read of the status address returns the lock-state vector, with bit n = 1 when lock n is held, and changes no lock.
- R6: Lock n is at byte address LOCK_BASE + 4·n (default LOCK_BASE = 0x100, 32 locks). The status word is at STATUS_ADDR (default 0x080), below the lock range.
- R7: An access whose address lies inside the lock range but has a nonzero value in bits [1:0] is ignored. A read of such an address returns 0.
- R8: A read of any address that is neither a lock nor the status word returns 0. A write to such an address changes no lock.
- R9: Read data is registered: a read strobe in cycle k gives `rsp_valid` = 1 and the result on `rsp_rdata` in cycle k+1. A cycle without a read strobe gives `rsp_valid` = 0 in the next cycle.
- R10: A write to the status address changes no lock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_rd | input | 1 | Read strobe |
| req_wr | input | 1 | Write strobe |
| req_addr | input | ADDR_W (12) | Byte address of the access |
| req_wdata | input | DATA_W (32) | Write data, ignored by lock releases |
| rsp_valid | output | 1 | High for one cycle when `rsp_rdata` holds a read result |
| rsp_rdata | output | DATA_W (32) | Registered read result |

## Verification
The assertions assume that the read and write strobes are never high in the same cycle, since the block does no arbitration. The bench drives each access from its own task, and every task raises exactly one strobe for one clock, so this assumption always holds. The assertions also assume that the address is stable while a strobe is high. The bench changes inputs only at the falling edge, and the design samples them at the rising edge.

// File: rtl/hwlock_pkg.sv
package hwlock_pkg;

  // How an address is classified by the decoder.
  typedef enum logic [1:0] {
    ACC_NONE   = 2'd0,
    ACC_LOCK   = 2'd1,
    ACC_STATUS = 2'd2
  } acc_kind_e;

endpackage

// File: rtl/hwlock_decode.sv
module hwlock_decode
  import hwlock_pkg::*;
#(
  parameter int NUM_LOCKS   = 32,
  parameter int ADDR_W      = 12,
  parameter int LOCK_BASE   = 'h100,
  parameter int STATUS_ADDR = 'h080
) (
  input  logic [ADDR_W-1:0]    addr,
  output logic [NUM_LOCKS-1:0] sel,
  output acc_kind_e            kind
);

  localparam logic [ADDR_W-1:0] STATUS_A = ADDR_W'(STATUS_ADDR);

  // One comparator per lock: only exact word addresses select a lock,
  // so misaligned offsets inside the range select nothing.
  for (genvar n = 0; n < NUM_LOCKS; n++) begin : g_sel
    localparam logic [ADDR_W-1:0] LOCK_A = ADDR_W'(LOCK_BASE + 4 * n);
    assign sel[n] = (addr == LOCK_A);
  end

  always_comb begin
    if (addr == STATUS_A)  kind = ACC_STATUS;
    else if (|sel)         kind = ACC_LOCK;
    else                   kind = ACC_NONE;
  end

endmodule

// File: rtl/hwlock_state.sv
module hwlock_state #(
  parameter int NUM_LOCKS = 32
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 rd,
  input  logic                 wr,
  input  logic [NUM_LOCKS-1:0] sel,
  output logic [NUM_LOCKS-1:0] held,
  output logic [NUM_LOCKS-1:0] grant
);

  // Each lock is one flop. Test and set happen in the same edge.
  for (genvar n = 0; n < NUM_LOCKS; n++) begin : g_lock
    logic bit_q;

    assign grant[n] = rd & sel[n] & ~bit_q;

    always_ff @(posedge clk) begin
      if (!rst_n)             bit_q <= 1'b0;
      else if (grant[n])      bit_q <= 1'b1;
      else if (wr && sel[n])  bit_q <= 1'b0;
    end

    assign held[n] = bit_q;
  end

endmodule

// File: rtl/hwlock_rdata.sv
module hwlock_rdata
  import hwlock_pkg::*;
#(
  parameter int NUM_LOCKS = 32,
  parameter int DATA_W    = 32
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 rd,
  input  acc_kind_e            kind,
  input  logic [NUM_LOCKS-1:0] held,
  input  logic [NUM_LOCKS-1:0] grant,
  output logic                 rvalid,
  output logic [DATA_W-1:0]    rdata
);

  logic [DATA_W-1:0] next_data;

  // The grant vector already is the one-hot claim mask, or zero on a miss.
  always_comb begin
    unique case (kind)
      ACC_STATUS: next_data = DATA_W'(held);
      ACC_LOCK:   next_data = DATA_W'(grant);
      default:    next_data = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rvalid <= 1'b0;
      rdata  <= '0;
    end else begin
      rvalid <= rd;
      rdata  <= rd ? next_data : '0;
    end
  end

endmodule

// File: rtl/hw_lock_bank.sv
module hw_lock_bank
  import hwlock_pkg::*;
#(
  parameter int NUM_LOCKS   = 32,
  parameter int ADDR_W      = 12,
  parameter int DATA_W      = 32,
  parameter int LOCK_BASE   = 'h100,
  parameter int STATUS_ADDR = 'h080
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_rd,
  input  logic              req_wr,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata
);

  logic [NUM_LOCKS-1:0] sel;
  logic [NUM_LOCKS-1:0] held_q;
  logic [NUM_LOCKS-1:0] grant;
  acc_kind_e            kind;

  // A release does not depend on the data written.
  wire unused_wdata = ^req_wdata;

  hwlock_decode #(
    .NUM_LOCKS  (NUM_LOCKS),
    .ADDR_W     (ADDR_W),
    .LOCK_BASE  (LOCK_BASE),
    .STATUS_ADDR(STATUS_ADDR)
  ) u_decode (
    .addr(req_addr),
    .sel (sel),
    .kind(kind)
  );

  hwlock_state #(
    .NUM_LOCKS(NUM_LOCKS)
  ) u_state (
    .clk  (clk),
    .rst_n(rst_n),
    .rd   (req_rd),
    .wr   (req_wr),
    .sel  (sel),
    .held (held_q),
    .grant(grant)
  );

  hwlock_rdata #(
    .NUM_LOCKS(NUM_LOCKS),
    .DATA_W   (DATA_W)
  ) u_rdata (
    .clk   (clk),
    .rst_n (rst_n),
    .rd    (req_rd),
    .kind  (kind),
    .held  (held_q),
    .grant (grant),
    .rvalid(rsp_valid),
    .rdata (rsp_rdata)
  );

endmodule

// File: rtl/hwlock_checker.sv
module hwlock_checker #(
  parameter int NUM_LOCKS   = 32,
  parameter int ADDR_W      = 12,
  parameter int DATA_W      = 32,
  parameter int LOCK_BASE   = 'h100,
  parameter int STATUS_ADDR = 'h080
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 req_rd,
  input logic                 req_wr,
  input logic [ADDR_W-1:0]    req_addr,
  input logic                 rsp_valid,
  input logic [DATA_W-1:0]    rsp_rdata,
  input logic [NUM_LOCKS-1:0] held
);

  localparam int LOCK_END = LOCK_BASE + 4 * NUM_LOCKS;

  function automatic logic in_range(input logic [ADDR_W-1:0] a);
    return (int'(a) >= LOCK_BASE) && (int'(a) < LOCK_END);
  endfunction

  function automatic logic is_lock(input logic [ADDR_W-1:0] a);
    return in_range(a) && (a[1:0] == 2'b00);
  endfunction

  function automatic int lock_idx(input logic [ADDR_W-1:0] a);
    return in_range(a) ? ((int'(a) - LOCK_BASE) >> 2) : 0;
  endfunction

  int idx_q;
  always_ff @(posedge clk) idx_q <= lock_idx(req_addr);

  logic cur_held;
  assign cur_held = held[lock_idx(req_addr)];

  // Assumption on the inputs: one access per cycle.
  p_one_access_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_rd && req_wr));

  p_claim_free_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_rd && is_lock(req_addr) && !cur_held) |=>
      (rsp_rdata == (DATA_W'(1) << idx_q)) && held[idx_q]);

  p_claim_busy_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (req_rd && is_lock(req_addr) && cur_held) |=>
      (rsp_rdata == '0) && (held == $past(held)));

  p_release_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (req_wr && is_lock(req_addr)) |=>
      !held[idx_q] && ($countones(held ^ $past(held)) <= 1));

  p_status_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (req_rd && (int'(req_addr) == STATUS_ADDR)) |=>
      (rsp_rdata == DATA_W'($past(held))) && $stable(held));

  p_misaligned_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ((req_rd || req_wr) && in_range(req_addr) && (req_addr[1:0] != 2'b00)) |=>
      (held == $past(held)) && (rsp_rdata == '0));

  p_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!req_rd && !req_wr) |=> $stable(held));

  p_valid_rd_r9: assert property (@(posedge clk) disable iff (!rst_n)
    req_rd |=> rsp_valid);

  p_valid_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !req_rd |=> !rsp_valid);

  p_status_wr_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (req_wr && (int'(req_addr) == STATUS_ADDR)) |=> $stable(held));

endmodule

bind hw_lock_bank hwlock_checker #(
  .NUM_LOCKS  (NUM_LOCKS),
  .ADDR_W     (ADDR_W),
  .DATA_W     (DATA_W),
  .LOCK_BASE  (LOCK_BASE),
  .STATUS_ADDR(STATUS_ADDR)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .req_rd   (req_rd),
  .req_wr   (req_wr),
  .req_addr (req_addr),
  .rsp_valid(rsp_valid),
  .rsp_rdata(rsp_rdata),
  .held     (held_q)
);

// File: tb/hw_lock_bank_bench.sv
`timescale 1ns/1ps
module hw_lock_bank_bench;

  localparam int N      = 32;
  localparam int AW     = 12;
  localparam int DW     = 32;
  localparam int BASE   = 'h100;
  localparam int STATUS = 'h080;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_rd = 1'b0;
  logic          req_wr = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_wdata = '0;
  logic          rsp_valid;
  logic [DW-1:0] rsp_rdata;

  int total = 0;
  int bad = 0;
  logic [N-1:0] model = '0;
  logic [DW-1:0] got;

  always #2 clk = ~clk;

  hw_lock_bank u_hw_lock_bank (
    .clk      (clk),
    .rst_n    (rst_n),
    .req_rd   (req_rd),
    .req_wr   (req_wr),
    .req_addr (req_addr),
    .req_wdata(req_wdata),
    .rsp_valid(rsp_valid),
    .rsp_rdata(rsp_rdata)
  );

  task automatic chk(input logic ok, input string tag,
                     input logic [DW-1:0] act, input logic [DW-1:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic do_rd(input int addr, output logic [DW-1:0] data);
    @(negedge clk);
    req_rd   = 1'b1;
    req_addr = AW'(addr);
    @(posedge clk);
    #1;
    data = rsp_rdata;
    chk(rsp_valid == 1'b1, "R9 valid after read", DW'(rsp_valid), 1);
    req_rd = 1'b0;
  endtask

  task automatic do_wr(input int addr, input logic [DW-1:0] data);
    @(negedge clk);
    req_wr    = 1'b1;
    req_addr  = AW'(addr);
    req_wdata = data;
    @(posedge clk);
    #1;
    chk(rsp_valid == 1'b0, "R9 no valid after write", DW'(rsp_valid), 0);
    req_wr = 1'b0;
  endtask

  task automatic chk_status(input string tag);
    logic [DW-1:0] s;
    do_rd(STATUS, s);
    chk(s == DW'(model), tag, s, DW'(model));
  endtask

  initial begin
    #(4 * 200000);
    bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (4) @(posedge clk);
    #1;
    chk(rsp_valid == 1'b0, "R1 reset valid", DW'(rsp_valid), 0);
    chk(rsp_rdata == '0, "R1 reset data", rsp_rdata, 0);
    @(negedge clk);
    rst_n = 1'b1;
    chk_status("R1 all free after reset");

    // R2 R6: claim every free lock at BASE + 4n.
    for (int n = 0; n < N; n++) begin
      do_rd(BASE + 4 * n, got);
      chk(got == (DW'(1) << n), "R2 R6 claim free", got, DW'(1) << n);
      model[n] = 1'b1;
      chk_status("R5 status after claim");
    end
    do_rd(STATUS, got);
    chk(got == '1, "R5 status repeat no side effect", got, '1);

    // R3: claiming held locks fails and changes nothing.
    for (int n = 0; n < N; n++) begin
      do_rd(BASE + 4 * n, got);
      chk(got == '0, "R3 claim busy", got, 0);
    end
    chk_status("R3 state unchanged");

    // R7: misaligned accesses inside the lock range.
    for (int n = 0; n < N; n += 5) begin
      for (int off = 1; off < 4; off++) begin
        do_rd(BASE + 4 * n + off, got);
        chk(got == '0, "R7 misaligned read", got, 0);
        do_wr(BASE + 4 * n + off, 32'hFFFF_FFFF);
      end
    end
    chk_status("R7 misaligned writes ignored");

    // R10: write to the status address.
    do_wr(STATUS, 32'h0000_0000);
    do_wr(STATUS, 32'hFFFF_FFFF);
    chk_status("R10 status write ignored");

    // R8: unmapped addresses.
    do_rd('h000, got);  chk(got == '0, "R8 read 0x000", got, 0);
    do_rd('h07C, got);  chk(got == '0, "R8 read 0x07C", got, 0);
    do_rd('h084, got);  chk(got == '0, "R8 read 0x084", got, 0);
    do_rd(BASE + 4 * N, got); chk(got == '0, "R8 read past end", got, 0);
    do_rd('hFFC, got);  chk(got == '0, "R8 read 0xFFC", got, 0);
    do_wr('h000, 32'h1);
    do_wr(BASE - 4, 32'h1);
    do_wr(BASE + 4 * N, 32'h1);
    chk_status("R8 unmapped writes ignored");

    // R4: release even locks with varied data, then the rest.
    for (int n = 0; n < N; n += 2) begin
      do_wr(BASE + 4 * n, DW'(n * 32'h1357_9BDF));
      model[n] = 1'b0;
      chk_status("R4 release one");
    end
    for (int n = 1; n < N; n += 2) begin
      do_wr(BASE + 4 * n, (n % 4 == 1) ? 32'h0 : 32'hFFFF_FFFF);
      model[n] = 1'b0;
    end
    chk_status("R4 all released");
    do_wr(BASE + 4 * 9, 32'hA5A5_A5A5);
    chk_status("R4 release of free lock");

    // R2 R3 R4: claim, retry, release, reclaim sequence.
    for (int n = 0; n < N; n += 3) begin
      do_rd(BASE + 4 * n, got);
      chk(got == (DW'(1) << n), "R2 reclaim", got, DW'(1) << n);
      do_rd(BASE + 4 * n, got);
      chk(got == '0, "R3 second claim", got, 0);
      do_wr(BASE + 4 * n, 32'h0);
      do_rd(BASE + 4 * n, got);
      chk(got == (DW'(1) << n), "R4 claim after release", got, DW'(1) << n);
      model[n] = 1'b1;
    end
    chk_status("R5 final status");

    // R9: idle cycle gives no valid.
    @(negedge clk);
    @(posedge clk);
    #1;
    chk(rsp_valid == 1'b0, "R9 idle no valid", DW'(rsp_valid), 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule